// File: doc/BRIEF.md
# Controller/PHY Update Handshake Engine

This block runs both update handshakes between a memory controller and its PHY on the controller side. It opens a controller update when the command scheduler reports an idle bus, or when the interval since the last controller update has run out. It holds that request for at least a minimum number of cycles and never longer than a maximum. The request stays up for as long as the PHY acknowledges it, provided the acknowledge arrived in time.

In the other direction, the block answers an update request from the PHY with an acknowledge. It keeps the acknowledge up until the PHY drops its request, and it flags a PHY that holds its request past the limit selected by the request's type. The two handshakes never overlap. While either one is open, a bus-hold output tells the scheduler to issue no commands or data.

All timing limits are inputs, driven from the controller's configuration registers. They are sampled live and are expected to change only under reset.

Top module: `upd_hs_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `ctrl_req_o`, `phy_ack_o`, `bus_hold_o`, `late_ack_o`, `overrun_o` and `phy_tmo_o` are all 0.
- R2: With no handshake open and `phy_req_i` low, `sched_idle_i` sampled high at a clock edge makes `ctrl_req_o` 1 after that edge.
- R3: Without an acknowledge, `ctrl_req_o` stays high for exactly `cfg_min_i` cycles (`cfg_min_i` >= 2).
- R4: An acknowledge that is first seen while the request has been high for fewer than `cfg_min_i` cycles is legal. While it stays high, the request is held. Once the request has been high for at least `cfg_min_i` cycles, it drops at the first edge that samples the acknowledge low.
- R5: The request never stays high for more than `cfg_max_i` cycles. If a legal acknowledge is still high at that point, the request is dropped anyway and `overrun_o` is set in the same edge.
- R6: An acknowledge first seen once the request has been high for `cfg_min_i` cycles or more is not honoured. The request drops at that edge and `late_ack_o` is set. Both flags clear when the next controller request starts.
- R7: With `sched_idle_i` held low and no PHY activity, successive rising edges of `ctrl_req_o` are exactly `cfg_intvl_i` cycles apart (`cfg_intvl_i` > `cfg_max_i`).
- R8: With no controller request open, `phy_ack_o` rises one cycle after `phy_req_i` is sampled high. It stays high while `phy_req_i` is high, and it falls at the first edge that samples `phy_req_i` low.
- R9: If a PHY request and a controller trigger arrive in the same cycle, the PHY is acknowledged first. The controller request starts one cycle after `phy_ack_o` falls. `ctrl_req_o` and `phy_ack_o` are never high together.
- R10: A PHY request that arrives while `ctrl_req_o` is high is not acknowledged until the cycle after `ctrl_req_o` has fallen.
- R11: `bus_hold_o` is high in every cycle in which `ctrl_req_o` or `phy_ack_o` is high.
- R12: The 2-bit `phy_type_i`, captured when the acknowledge rises, selects the hold limit `cfg_phy_lim_i[type*LIM_W +: LIM_W]`. `phy_tmo_o` is set if `phy_req_i` is still sampled high on more than that many edges after the acknowledge rises. It clears at the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_idle_i | input | 1 | Scheduler reports an idle bus; opportunity to start a controller update |
| cfg_min_i | input | CNT_W | Minimum controller request length, in cycles |
| cfg_max_i | input | CNT_W | Maximum controller request length, in cycles |
| cfg_intvl_i | input | IVL_W | Maximum spacing between controller request rises |
| cfg_phy_lim_i | input | 4*LIM_W | Four PHY hold limits, one per request type |
| ctrl_ack_i | input | 1 | PHY acknowledge of the controller request |
| phy_req_i | input | 1 | PHY update request |
| phy_type_i | input | 2 | PHY update type |
| ctrl_req_o | output | 1 | Controller update request to the PHY |
| phy_ack_o | output | 1 | Acknowledge of the PHY update request |
| bus_hold_o | output | 1 | Scheduler must keep the bus idle |
| late_ack_o | output | 1 | Acknowledge came after the legal window |
| overrun_o | output | 1 | Acknowledge still high when the maximum was reached |
| phy_tmo_o | output | 1 | PHY held its request beyond its type limit |

## Verification
The bench aims at the edges of the legal acknowledge window. An acknowledge sampled in the last cycle before the minimum is honoured, while one sampled at the minimum must drop the request and raise the late flag. An engine that compares with the wrong inequality shortens or lengthens the request by one cycle, or honours an illegal acknowledge. A stuck acknowledge shows whether the maximum truly caps the request, since a broken cap leaves the bus held forever. The priority and waiting cases catch an arbiter that lets both handshakes open together or starts the deferred one a cycle early. The PHY timeout is run one edge either side of its limit, and with a second type, to expose off-by-one counting and a wrong limit selection.

// File: rtl/upd_hs_pkg.sv
package upd_hs_pkg;
  localparam int unsigned N_PHY_TYPES = 4;
  localparam int unsigned TYPE_W      = $clog2(N_PHY_TYPES);

  typedef enum logic {
    C_IDLE = 1'b0,
    C_REQ  = 1'b1
  } ctrl_st_e;

  typedef enum logic {
    P_IDLE = 1'b0,
    P_ACK  = 1'b1
  } phy_st_e;
endpackage

// File: rtl/upd_ctrl_side.sv
module upd_ctrl_side
  import upd_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_idle,
  input  logic             blocked,
  input  logic [CNT_W-1:0] cfg_min,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic [IVL_W-1:0] cfg_intvl,
  input  logic             ack_in,
  output logic             req_o,
  output logic             late_o,
  output logic             ovr_o
);
  localparam logic [IVL_W-1:0] IVL_SAT = {IVL_W{1'b1}};

  ctrl_st_e         st;
  logic [CNT_W-1:0] hi_cnt;   // cycles the request has been high, 1 in first cycle
  logic [IVL_W-1:0] ivl_cnt;  // cycles since last request rise
  logic             ack_ok;   // a legal acknowledge has been seen

  logic ivl_due, start, ok_now, at_min, at_max, drop;

  always_comb begin
    ivl_due = (ivl_cnt >= cfg_intvl);
    start   = (st == C_IDLE) && (trig_idle || ivl_due) && !blocked;
    ok_now  = ack_ok || (ack_in && (hi_cnt < cfg_min));
    at_min  = (hi_cnt >= cfg_min);
    at_max  = (hi_cnt >= cfg_max);
    drop    = at_max || (at_min && !(ack_in && ok_now));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= C_IDLE;
      req_o   <= 1'b0;
      hi_cnt  <= '0;
      ivl_cnt <= '0;
      ack_ok  <= 1'b0;
      late_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (ivl_cnt != IVL_SAT) ivl_cnt <= ivl_cnt + 1'b1;
      unique case (st)
        C_IDLE: begin
          if (start) begin
            st      <= C_REQ;
            req_o   <= 1'b1;
            hi_cnt  <= CNT_W'(1);
            ivl_cnt <= IVL_W'(1);
            ack_ok  <= 1'b0;
            late_o  <= 1'b0;
            ovr_o   <= 1'b0;
          end
        end
        C_REQ: begin
          if (ack_in && !ok_now && at_min) late_o <= 1'b1;
          if (ok_now) ack_ok <= 1'b1;
          if (drop) begin
            st    <= C_IDLE;
            req_o <= 1'b0;
            if (at_max && ack_in && ok_now) ovr_o <= 1'b1;
          end else begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upd_phy_side.sv
module upd_phy_side
  import upd_hs_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_in,
  input  logic [TYPE_W-1:0]            type_in,
  input  logic                         ctrl_busy,
  input  logic [N_PHY_TYPES*LIM_W-1:0] lim_flat,
  output logic                         ack_o,
  output logic                         tmo_o
);
  localparam logic [LIM_W-1:0] HC_SAT = {LIM_W{1'b1}};

  logic [LIM_W-1:0] lim_a [N_PHY_TYPES];

  for (genvar t = 0; t < N_PHY_TYPES; t++) begin : g_lim
    assign lim_a[t] = lim_flat[t*LIM_W +: LIM_W];
  end

  phy_st_e           st;
  logic [TYPE_W-1:0] type_q;
  logic [LIM_W-1:0]  hold_cnt;
  logic [LIM_W-1:0]  sel_lim;

  assign sel_lim = lim_a[type_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= P_IDLE;
      ack_o    <= 1'b0;
      tmo_o    <= 1'b0;
      type_q   <= '0;
      hold_cnt <= '0;
    end else begin
      unique case (st)
        P_IDLE: begin
          if (req_in && !ctrl_busy) begin
            st       <= P_ACK;
            ack_o    <= 1'b1;
            type_q   <= type_in;
            hold_cnt <= LIM_W'(1);
            tmo_o    <= 1'b0;
          end
        end
        P_ACK: begin
          if (!req_in) begin
            st    <= P_IDLE;
            ack_o <= 1'b0;
          end else begin
            if (hold_cnt > sel_lim) tmo_o <= 1'b1;
            if (hold_cnt != HC_SAT) hold_cnt <= hold_cnt + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upd_hs_engine.sv
module upd_hs_engine
  import upd_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IVL_W = 16,
  parameter int unsigned LIM_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sched_idle_i,
  input  logic [CNT_W-1:0]             cfg_min_i,
  input  logic [CNT_W-1:0]             cfg_max_i,
  input  logic [IVL_W-1:0]             cfg_intvl_i,
  input  logic [N_PHY_TYPES*LIM_W-1:0] cfg_phy_lim_i,
  input  logic                         ctrl_ack_i,
  input  logic                         phy_req_i,
  input  logic [TYPE_W-1:0]            phy_type_i,
  output logic                         ctrl_req_o,
  output logic                         phy_ack_o,
  output logic                         bus_hold_o,
  output logic                         late_ack_o,
  output logic                         overrun_o,
  output logic                         phy_tmo_o
);
  // PHY wins ties: a pending or open PHY update blocks a controller start.
  logic ctrl_blocked;
  assign ctrl_blocked = phy_req_i || phy_ack_o;

  upd_ctrl_side #(.CNT_W(CNT_W), .IVL_W(IVL_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .trig_idle (sched_idle_i),
    .blocked   (ctrl_blocked),
    .cfg_min   (cfg_min_i),
    .cfg_max   (cfg_max_i),
    .cfg_intvl (cfg_intvl_i),
    .ack_in    (ctrl_ack_i),
    .req_o     (ctrl_req_o),
    .late_o    (late_ack_o),
    .ovr_o     (overrun_o)
  );

  upd_phy_side #(.LIM_W(LIM_W)) phy_i (
    .clk       (clk),
    .rst       (rst),
    .req_in    (phy_req_i),
    .type_in   (phy_type_i),
    .ctrl_busy (ctrl_req_o),
    .lim_flat  (cfg_phy_lim_i),
    .ack_o     (phy_ack_o),
    .tmo_o     (phy_tmo_o)
  );

  assign bus_hold_o = ctrl_req_o || phy_ack_o;
endmodule

// File: rtl/upd_hs_engine_chk.sv
module upd_hs_engine_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_min_i,
  input logic [CNT_W-1:0] cfg_max_i,
  input logic             phy_req_i,
  input logic             ctrl_req_o,
  input logic             phy_ack_o,
  input logic             overrun_o
);
  logic [CNT_W:0] prior_hi;  // high cycles of the request before the current one

  always_ff @(posedge clk) begin
    if (rst)             prior_hi <= '0;
    else if (ctrl_req_o) prior_hi <= prior_hi + 1'b1;
    else                 prior_hi <= '0;
  end

  // R3: request is held until the minimum has been served
  a_r3_min_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl_req_o && (prior_hi + 1'b1 < {1'b0, cfg_min_i})) |=> ctrl_req_o);

  // R3: a falling request has served at least the minimum
  a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_req_o) |-> (prior_hi >= {1'b0, cfg_min_i}));

  // R5: request never exceeds the maximum
  a_r5_max_cap: assert property (@(posedge clk) disable iff (rst)
    ctrl_req_o |-> (prior_hi < {1'b0, cfg_max_i}));

  // R5: overrun flag only rises together with the request falling
  a_r5_ovr_at_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $fell(ctrl_req_o));

  // R8: acknowledge rises only in answer to a request
  a_r8_ack_answers: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_ack_o) |-> $past(phy_req_i));

  // R8: acknowledge follows the request down
  a_r8_ack_release: assert property (@(posedge clk) disable iff (rst)
    (phy_ack_o && !phy_req_i) |=> !phy_ack_o);

  // R9: the two handshakes never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_req_o && phy_ack_o));
endmodule

bind upd_hs_engine upd_hs_engine_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_min_i  (cfg_min_i),
  .cfg_max_i  (cfg_max_i),
  .phy_req_i  (phy_req_i),
  .ctrl_req_o (ctrl_req_o),
  .phy_ack_o  (phy_ack_o),
  .overrun_o  (overrun_o)
);

// File: tb/upd_hs_engine_tb_top.sv
`timescale 1ns/1ps
module upd_hs_engine_tb_top;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned IVL_W = 16;
  localparam int unsigned LIM_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sched_idle = 1'b0;
  logic [CNT_W-1:0] cfg_min = 8'd4;
  logic [CNT_W-1:0] cfg_max = 8'd12;
  logic [IVL_W-1:0] cfg_intvl = 16'hFFFF;
  logic [4*LIM_W-1:0] cfg_lim = {8'd20, 8'd6, 8'd9, 8'd3};
  logic ctrl_ack = 1'b0;
  logic phy_req = 1'b0;
  logic [1:0] phy_type = 2'd0;
  logic ctrl_req, phy_ack, bus_hold, late_ack, overrun, phy_tmo;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  upd_hs_engine #(.CNT_W(CNT_W), .IVL_W(IVL_W), .LIM_W(LIM_W)) dut_i (
    .clk(clk), .rst(rst), .sched_idle_i(sched_idle),
    .cfg_min_i(cfg_min), .cfg_max_i(cfg_max), .cfg_intvl_i(cfg_intvl),
    .cfg_phy_lim_i(cfg_lim), .ctrl_ack_i(ctrl_ack), .phy_req_i(phy_req),
    .phy_type_i(phy_type), .ctrl_req_o(ctrl_req), .phy_ack_o(phy_ack),
    .bus_hold_o(bus_hold), .late_ack_o(late_ack), .overrun_o(overrun),
    .phy_tmo_o(phy_tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit check_r1);
    rst = 1'b1; sched_idle = 0; ctrl_ack = 0; phy_req = 0;
    repeat (3) @(negedge clk);
    if (check_r1) chk("R1 outputs in reset",
      {ctrl_req, phy_ack, bus_hold, late_ack, overrun, phy_tmo}, 0);
    rst = 1'b0;
    @(negedge clk);
    if (check_r1) chk("R1 outputs after reset",
      {ctrl_req, phy_ack, bus_hold, late_ack, overrun, phy_tmo}, 0);
  endtask

  // R2 R3 R11: idle trigger, no acknowledge
  task automatic t_idle_start();
    int n;
    do_reset(0);
    sched_idle = 1;
    @(negedge clk);
    chk("R2 request after idle", ctrl_req, 1);
    chk("R11 hold with request", bus_hold, 1);
    sched_idle = 0;
    n = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ctrl_req) n++; else break;
    end
    chk("R3 length without ack", n, 4);
    chk("R11 hold released", bus_hold, 0);
  endtask

  // R4: legal acknowledge extends the request
  task automatic t_ack_extend();
    do_reset(0);
    sched_idle = 1;
    @(negedge clk);
    sched_idle = 0;
    ctrl_ack = 1;
    repeat (7) @(negedge clk);
    chk("R4 held while ack", ctrl_req, 1);
    ctrl_ack = 0;
    @(negedge clk);
    chk("R4 drop after ack low", ctrl_req, 0);
    chk("R6 no late flag", late_ack, 0);
  endtask

  // R5: stuck acknowledge capped at maximum
  task automatic t_max();
    do_reset(0);
    sched_idle = 1;
    @(negedge clk);
    sched_idle = 0;
    ctrl_ack = 1;
    repeat (11) @(negedge clk);
    chk("R5 high in last max cycle", ctrl_req, 1);
    @(negedge clk);
    chk("R5 drop at max", ctrl_req, 0);
    chk("R5 overrun flag", overrun, 1);
    ctrl_ack = 0;
  endtask

  // R6: acknowledge at the minimum is late
  task automatic t_late();
    do_reset(0);
    sched_idle = 1;
    @(negedge clk);
    sched_idle = 0;
    repeat (3) @(negedge clk);
    chk("R6 still high at min cycle", ctrl_req, 1);
    ctrl_ack = 1;
    @(negedge clk);
    chk("R6 late ack not honoured", ctrl_req, 0);
    chk("R6 late flag", late_ack, 1);
    ctrl_ack = 0;
    sched_idle = 1;
    @(negedge clk);
    sched_idle = 0;
    chk("R6 flag cleared on new request", late_ack, 0);
    repeat (6) @(negedge clk);
  endtask

  // R7: interval timer forces requests
  task automatic t_interval();
    int r0, r1;
    bit prev;
    r0 = -1; r1 = -1; prev = 0;
    cfg_intvl = 16'd20;
    do_reset(0);
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      if (ctrl_req && !prev) begin
        if (r0 < 0) r0 = i; else if (r1 < 0) r1 = i;
      end
      prev = ctrl_req;
    end
    chk("R7 spacing between rises", r1 - r0, 20);
    cfg_intvl = 16'hFFFF;
  endtask

  // R8 R11: PHY request acknowledged and released
  task automatic t_phy();
    do_reset(0);
    phy_req = 1;
    @(negedge clk);
    chk("R8 ack one cycle later", phy_ack, 1);
    chk("R11 hold with ack", bus_hold, 1);
    sched_idle = 1;
    repeat (4) @(negedge clk);
    chk("R9 no ctrl during phy", ctrl_req, 0);
    sched_idle = 0;
    phy_req = 0;
    chk("R8 ack held with request", phy_ack, 1);
    @(negedge clk);
    chk("R8 ack released", phy_ack, 0);
  endtask

  // R9: coincident triggers, PHY first
  task automatic t_priority();
    do_reset(0);
    sched_idle = 1;
    phy_req = 1;
    @(negedge clk);
    chk("R9 phy served first", phy_ack, 1);
    chk("R9 ctrl deferred", ctrl_req, 0);
    repeat (3) @(negedge clk);
    phy_req = 0;
    @(negedge clk);
    chk("R9 ack dropped", phy_ack, 0);
    chk("R9 ctrl not yet", ctrl_req, 0);
    @(negedge clk);
    chk("R9 ctrl starts after phy", ctrl_req, 1);
    sched_idle = 0;
    repeat (8) @(negedge clk);
  endtask

  // R10: PHY request waits for open controller request
  task automatic t_phy_wait();
    do_reset(0);
    sched_idle = 1;
    @(negedge clk);
    sched_idle = 0;
    phy_req = 1;
    repeat (3) @(negedge clk);
    chk("R10 no ack during ctrl", phy_ack, 0);
    @(negedge clk);
    chk("R10 ctrl dropped", ctrl_req, 0);
    chk("R10 no ack same cycle", phy_ack, 0);
    @(negedge clk);
    chk("R10 ack after ctrl", phy_ack, 1);
    phy_req = 0;
    @(negedge clk);
  endtask

  // R12: per-type hold limit
  task automatic t_tmo(input logic [1:0] ty, input int extra, input int exp, input string tag);
    do_reset(0);
    phy_type = ty;
    phy_req = 1;
    @(negedge clk);
    phy_type = ~ty;
    repeat (extra) @(negedge clk);
    phy_req = 0;
    repeat (2) @(negedge clk);
    chk(tag, phy_tmo, exp);
  endtask

  initial begin
    do_reset(1);
    t_idle_start();
    t_ack_extend();
    t_max();
    t_late();
    t_interval();
    t_phy();
    t_priority();
    t_phy_wait();
    t_tmo(2'd2, 6, 0, "R12 type2 at limit");
    t_tmo(2'd2, 7, 1, "R12 type2 past limit");
    t_tmo(2'd3, 7, 0, "R12 type3 larger limit");
    t_tmo(2'd0, 4, 1, "R12 type0 past limit");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule